// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative translation cache. Each entry pairs a virtual page number with a physical page number and a set of access attributes. These attributes are four per-mode read enables, four per-mode write enables, a fault-on-read flag and a fault-on-write flag. Each entry also carries an address space number and a global flag, which makes the entry visible to every address space.

Software fills an entry in two steps. First it writes a packed attribute word into a staging register. Then it issues a tag write that carries the virtual page. On the tag write, the block builds the entry from the staged word and from the current address space number, and installs it.

A lookup is combinational from the stored state. Three kinds of invalidation are supported:
- a global flush of all entries;
- a flush of the process-local entries only, which keeps the global ones;
- removal of a single page in the current address space.

A parameter selects an instruction-side variant, in which stored write enables are always zero.

Top module: `xlate_buf`

## Requirements
- R1: After reset no entry is valid: every lookup misses, and the fill error flag reads 0.
- R2: A tag write installs an entry built from the staged word and `cur_asn`, and the entry is visible to lookups from the next clock edge. The staged word layout is: bit 1 fault-on-read, bit 2 fault-on-write, bit 4 global, bits 6:5 granularity hint, bits 11:8 read enables, bits 15:12 write enables, bits 58:32 the 27-bit physical page.
- R3: A lookup hits when a valid entry has the same virtual page and either its stored address space number equals `cur_asn` or its global bit is set. On a miss, every lookup output field is zero.
- R4: A tag write whose staged granularity hint (bits 6:5) is nonzero leaves the entries unchanged. `fill_err` is then high for exactly the following cycle.
- R5: `flush_all` invalidates every entry.
- R6: `flush_proc` invalidates only the entries whose global bit is clear.
- R7: `flush_one` invalidates the entry that a lookup of `flush_vpn` under `cur_asn` would hit. Entries in other address spaces are kept.
- R8: A fill that matches no existing entry goes to a round-robin slot over the entries. The ninth distinct fill after reset therefore replaces the first one.
- R9: A fill that matches an existing entry (same page, and same address space or either side global) overwrites that entry and does not advance the round-robin slot. A lookup never matches more than one entry.
- R10: Flush commands take priority over a tag write in the same cycle, and that fill is dropped.
- R11: In the instruction-side variant (`INSN_SIDE`=1), the write enables of a looked-up entry are always 0.
- R12: A tag write in the same cycle as a staging write uses the word staged before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_we | input | 1 | Write the staging register |
| stage_word | input | 64 | Packed attribute word |
| tag_we | input | 1 | Install an entry from the staged word |
| tag_vpn | input | VPN_W | Virtual page for the fill |
| cur_asn | input | ASN_W | Current address space number |
| flush_all | input | 1 | Invalidate all entries |
| flush_proc | input | 1 | Invalidate non-global entries |
| flush_one | input | 1 | Invalidate one page in current space |
| flush_vpn | input | VPN_W | Page for `flush_one` |
| look_vpn | input | VPN_W | Lookup page |
| look_hit | output | 1 | Lookup hit |
| look_ppn | output | 27 | Physical page of the hit |
| look_rd_en | output | 4 | Read enables of the hit |
| look_wr_en | output | 4 | Write enables of the hit |
| look_flt_rd | output | 1 | Fault-on-read of the hit |
| look_flt_wr | output | 1 | Fault-on-write of the hit |
| look_glob | output | 1 | Global bit of the hit |
| fill_err | output | 1 | Rejected fill, one cycle after it |

## Verification
The assertions assume that at most one command source matters per cycle, following the stated priority: all-flush, then process flush, then single flush, then fill. They also assume that the staged word is a register value, so the granularity hint checked at a tag write is the one staged earlier. The stimulus drives each command for exactly one cycle between falling edges, and reaches the same-cycle cases only on purpose, for the priority and staging requirements. Every fill is given a page and address space chosen so that the expected victim slot follows from simple counting.

// File: rtl/xb_pkg.sv
package xb_pkg;
  localparam int WORD_W     = 64;
  localparam int FLT_RD_BIT = 1;
  localparam int FLT_WR_BIT = 2;
  localparam int GLOB_BIT   = 4;
  localparam int GH_LO      = 5;
  localparam int GH_W       = 2;
  localparam int RD_LO      = 8;
  localparam int WR_LO      = 12;
  localparam int PERM_W     = 4;
  localparam int PPN_LO     = 32;
  localparam int PPN_W      = 27;
endpackage

// File: rtl/xb_match.sv
module xb_match #(
  parameter int N     = 8,
  parameter int VPN_W = 12,
  parameter int ASN_W = 7
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0][VPN_W-1:0]  vpn_arr,
  input  logic [N-1:0][ASN_W-1:0]  asn_arr,
  input  logic [N-1:0]             glob,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [ASN_W-1:0]         key_asn,
  input  logic                     key_glob,
  output logic [N-1:0]             hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = valid[i] && (vpn_arr[i] == key_vpn) &&
                    ((asn_arr[i] == key_asn) || glob[i] || key_glob);
  end
endmodule

// File: rtl/xb_pick.sv
module xb_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/xb_victim.sv
module xb_victim #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
  import xb_pkg::*;
#(
  parameter int N         = 8,
  parameter int VPN_W     = 12,
  parameter int ASN_W     = 7,
  parameter int INSN_SIDE = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stage_we,
  input  logic [WORD_W-1:0]  stage_word,
  input  logic               tag_we,
  input  logic [VPN_W-1:0]   tag_vpn,
  input  logic [ASN_W-1:0]   cur_asn,
  input  logic               flush_all,
  input  logic               flush_proc,
  input  logic               flush_one,
  input  logic [VPN_W-1:0]   flush_vpn,
  input  logic [VPN_W-1:0]   look_vpn,
  output logic               look_hit,
  output logic [PPN_W-1:0]   look_ppn,
  output logic [PERM_W-1:0]  look_rd_en,
  output logic [PERM_W-1:0]  look_wr_en,
  output logic               look_flt_rd,
  output logic               look_flt_wr,
  output logic               look_glob,
  output logic               fill_err
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]              valid_q, valid_d;
  logic [N-1:0][VPN_W-1:0]   vpn_q, vpn_d;
  logic [N-1:0][ASN_W-1:0]   asn_q, asn_d;
  logic [N-1:0][PPN_W-1:0]   ppn_q, ppn_d;
  logic [N-1:0][PERM_W-1:0]  rd_q, rd_d, wr_q, wr_d;
  logic [N-1:0]              frd_q, frd_d, fwr_q, fwr_d, glob_q, glob_d;
  logic [WORD_W-1:0]         stage_q, stage_d;
  logic                      err_q, err_d;

  // Fields decoded from the staged word
  logic                      gh_bad, new_glob;
  logic [PERM_W-1:0]         new_wr;
  assign gh_bad   = |stage_q[GH_LO +: GH_W];
  assign new_glob = stage_q[GLOB_BIT];
  assign new_wr   = (INSN_SIDE != 0) ? '0 : stage_q[WR_LO +: PERM_W];

  // Three comparators: lookup, single flush, fill
  logic [N-1:0] lk_hit_vec, one_hit, fl_hit;
  xb_match #(.N(N), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk (
    .valid(valid_q), .vpn_arr(vpn_q), .asn_arr(asn_q), .glob(glob_q),
    .key_vpn(look_vpn), .key_asn(cur_asn), .key_glob(1'b0), .hit(lk_hit_vec));
  xb_match #(.N(N), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_one (
    .valid(valid_q), .vpn_arr(vpn_q), .asn_arr(asn_q), .glob(glob_q),
    .key_vpn(flush_vpn), .key_asn(cur_asn), .key_glob(1'b0), .hit(one_hit));
  xb_match #(.N(N), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl (
    .valid(valid_q), .vpn_arr(vpn_q), .asn_arr(asn_q), .glob(glob_q),
    .key_vpn(tag_vpn), .key_asn(cur_asn), .key_glob(new_glob), .hit(fl_hit));

  logic             lk_any, fl_any;
  logic [IDX_W-1:0] lk_idx, fl_idx, rr_ptr, tgt;
  xb_pick #(.N(N), .IDX_W(IDX_W)) u_pk_lk (.req(lk_hit_vec), .any(lk_any), .idx(lk_idx));
  xb_pick #(.N(N), .IDX_W(IDX_W)) u_pk_fl (.req(fl_hit), .any(fl_any), .idx(fl_idx));

  logic flush_any, fill_ok, rr_adv;
  assign flush_any = flush_all | flush_proc | flush_one;
  assign fill_ok   = tag_we & ~gh_bad & ~flush_any;
  assign rr_adv    = fill_ok & ~fl_any;
  assign tgt       = fl_any ? fl_idx : rr_ptr;

  xb_victim #(.N(N), .IDX_W(IDX_W)) u_rr (
    .clk(clk), .rst_n(rst_n), .adv(rr_adv), .ptr(rr_ptr));

  // Next state
  always_comb begin
    valid_d = valid_q; vpn_d = vpn_q; asn_d = asn_q; ppn_d = ppn_q;
    rd_d = rd_q; wr_d = wr_q; frd_d = frd_q; fwr_d = fwr_q; glob_d = glob_q;
    stage_d = stage_we ? stage_word : stage_q;
    err_d   = tag_we & gh_bad;
    if (flush_all) begin
      valid_d = '0;
    end else if (flush_proc) begin
      valid_d = valid_q & glob_q;
    end else if (flush_one) begin
      valid_d = valid_q & ~one_hit;
    end else if (fill_ok) begin
      valid_d      = valid_q & ~fl_hit;
      valid_d[tgt] = 1'b1;
      vpn_d[tgt]   = tag_vpn;
      asn_d[tgt]   = cur_asn;
      ppn_d[tgt]   = stage_q[PPN_LO +: PPN_W];
      rd_d[tgt]    = stage_q[RD_LO +: PERM_W];
      wr_d[tgt]    = new_wr;
      frd_d[tgt]   = stage_q[FLT_RD_BIT];
      fwr_d[tgt]   = stage_q[FLT_WR_BIT];
      glob_d[tgt]  = new_glob;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0; vpn_q <= '0; asn_q <= '0; ppn_q <= '0;
      rd_q <= '0; wr_q <= '0; frd_q <= '0; fwr_q <= '0; glob_q <= '0;
      stage_q <= '0; err_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      if (stage_we) stage_q <= stage_d;
      if (fill_ok) begin
        vpn_q <= vpn_d; asn_q <= asn_d; ppn_q <= ppn_d; rd_q <= rd_d;
        wr_q <= wr_d; frd_q <= frd_d; fwr_q <= fwr_d; glob_q <= glob_d;
      end
    end
  end

  // Lookup outputs
  assign look_hit    = lk_any;
  assign look_ppn    = lk_any ? ppn_q[lk_idx] : '0;
  assign look_rd_en  = lk_any ? rd_q[lk_idx]  : '0;
  assign look_wr_en  = lk_any ? wr_q[lk_idx]  : '0;
  assign look_flt_rd = lk_any & frd_q[lk_idx];
  assign look_flt_wr = lk_any & fwr_q[lk_idx];
  assign look_glob   = lk_any & glob_q[lk_idx];
  assign fill_err    = err_q;
endmodule

// File: rtl/xlate_buf_chk.sv
module xlate_buf_chk #(
  parameter int N         = 8,
  parameter int INSN_SIDE = 0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tag_we,
  input logic         stage_we,
  input logic         flush_all,
  input logic         flush_proc,
  input logic         flush_one,
  input logic [63:0]  stage_q,
  input logic [N-1:0] valid_q,
  input logic [N-1:0] glob_q,
  input logic [N-1:0] lk_hit_vec,
  input logic         fill_err,
  input logic         look_hit,
  input logic [3:0]   look_wr_en
);
  p_single_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec));

  p_flush_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0));

  p_flush_proc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_proc && !flush_all) |=> ((valid_q & ~glob_q) == '0));

  p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_we && (stage_q[6:5] != 2'b00)) |=> fill_err);

  p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |-> $past(tag_we));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tag_we && !flush_all && !flush_proc && !flush_one) |=> $stable(valid_q));

  p_no_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (look_hit && (INSN_SIDE != 0)) |-> (look_wr_en == 4'd0));
endmodule

bind xlate_buf xlate_buf_chk #(.N(N), .INSN_SIDE(INSN_SIDE)) u_chk (
  .clk(clk), .rst_n(rst_n), .tag_we(tag_we), .stage_we(stage_we),
  .flush_all(flush_all), .flush_proc(flush_proc), .flush_one(flush_one),
  .stage_q(stage_q), .valid_q(valid_q), .glob_q(glob_q),
  .lk_hit_vec(lk_hit_vec), .fill_err(fill_err), .look_hit(look_hit),
  .look_wr_en(look_wr_en));

// File: tb/sim_xlate_buf.sv
`timescale 1ns/1ps
module sim_xlate_buf;
  localparam int VPN_W = 12;
  localparam int ASN_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stage_we = 1'b0, tag_we = 1'b0;
  logic flush_all = 1'b0, flush_proc = 1'b0, flush_one = 1'b0;
  logic [63:0] stage_word = '0;
  logic [VPN_W-1:0] tag_vpn = '0, flush_vpn = '0, look_vpn = '0;
  logic [ASN_W-1:0] cur_asn = '0;

  logic hit0, frd0, fwr0, glb0, err0;
  logic [26:0] ppn0;
  logic [3:0] rd0, wr0;
  logic hit1, frd1, fwr1, glb1, err1;
  logic [26:0] ppn1;
  logic [3:0] rd1, wr1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xlate_buf #(.VPN_W(VPN_W), .ASN_W(ASN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .stage_we(stage_we), .stage_word(stage_word),
    .tag_we(tag_we), .tag_vpn(tag_vpn), .cur_asn(cur_asn),
    .flush_all(flush_all), .flush_proc(flush_proc), .flush_one(flush_one),
    .flush_vpn(flush_vpn), .look_vpn(look_vpn), .look_hit(hit0),
    .look_ppn(ppn0), .look_rd_en(rd0), .look_wr_en(wr0),
    .look_flt_rd(frd0), .look_flt_wr(fwr0), .look_glob(glb0), .fill_err(err0));

  xlate_buf #(.VPN_W(VPN_W), .ASN_W(ASN_W), .INSN_SIDE(1)) u1 (
    .clk(clk), .rst_n(rst_n), .stage_we(stage_we), .stage_word(stage_word),
    .tag_we(tag_we), .tag_vpn(tag_vpn), .cur_asn(cur_asn),
    .flush_all(flush_all), .flush_proc(flush_proc), .flush_one(flush_one),
    .flush_vpn(flush_vpn), .look_vpn(look_vpn), .look_hit(hit1),
    .look_ppn(ppn1), .look_rd_en(rd1), .look_wr_en(wr1),
    .look_flt_rd(frd1), .look_flt_wr(fwr1), .look_glob(glb1), .fill_err(err1));

  function automatic logic [63:0] mkw(input int ppn, input int re, input int we,
                                      input bit fr, input bit fw, input bit g,
                                      input int gh);
    logic [63:0] w;
    w = '0;
    w[58:32] = ppn[26:0];
    w[11:8]  = re[3:0];
    w[15:12] = we[3:0];
    w[1] = fr; w[2] = fw; w[4] = g;
    w[6:5] = gh[1:0];
    return w;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic look(input int vpn, input int asn);
    look_vpn = VPN_W'(vpn);
    cur_asn  = ASN_W'(asn);
    #1;
  endtask

  task automatic stage(input logic [63:0] w);
    @(negedge clk); stage_we = 1'b1; stage_word = w;
    @(negedge clk); stage_we = 1'b0;
  endtask

  task automatic tag(input int vpn, input int asn);
    @(negedge clk); tag_we = 1'b1; tag_vpn = VPN_W'(vpn); cur_asn = ASN_W'(asn);
    @(negedge clk); tag_we = 1'b0;
  endtask

  task automatic fill(input int vpn, input int asn, input logic [63:0] w);
    stage(w);
    tag(vpn, asn);
  endtask

  task automatic expect_hit(input string req, input int vpn, input int asn, input int ppn);
    look(vpn, asn);
    chk(req, {63'd0, hit0}, 64'd1);
    chk(req, {37'd0, ppn0}, 64'(ppn));
  endtask

  task automatic expect_miss(input string req, input int vpn, input int asn);
    look(vpn, asn);
    chk(req, {63'd0, hit0}, 64'd0);
    chk(req, {37'd0, ppn0}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int v = 0; v < 4; v++) expect_miss("R1", v, 0);
    chk("R1", {63'd0, err0}, 64'd0);

    // R2: fill eight entries and read every field back
    for (int i = 0; i < 8; i++)
      fill(i + 1, 3, mkw(i * 5 + 7, i, 15 - i, i[0], i[1], 1'b0, 0));
    for (int i = 0; i < 8; i++) begin
      expect_hit("R2", i + 1, 3, i * 5 + 7);
      chk("R2", {60'd0, rd0}, 64'(i));
      chk("R2", {60'd0, wr0}, 64'(15 - i));
      chk("R2", {62'd0, fwr0, frd0}, 64'(i % 4));
      chk("R2", {63'd0, glb0}, 64'd0);
    end

    // R3: address space sweep on a local entry
    for (int a = 0; a < 8; a++) begin
      look(1, a);
      chk("R3", {63'd0, hit0}, (a == 3) ? 64'd1 : 64'd0);
    end

    // R8: ninth distinct fill replaces the first slot
    fill(100, 3, mkw(300, 1, 1, 0, 0, 0, 0));
    expect_miss("R8", 1, 3);
    expect_hit("R8", 100, 3, 300);
    expect_hit("R8", 2, 3, 12);

    // R9: matching refill in place, pointer held at slot 1
    fill(2, 3, mkw(999, 2, 2, 0, 0, 0, 0));
    expect_hit("R9", 2, 3, 999);
    fill(101, 3, mkw(301, 0, 0, 0, 0, 0, 0));
    expect_miss("R9", 2, 3);
    expect_hit("R9", 3, 3, 17);
    expect_hit("R9", 101, 3, 301);

    // R3: global entry visible from any space (takes slot 2)
    fill(200, 3, mkw(555, 3, 0, 0, 0, 1'b1, 0));
    for (int a = 0; a < 4; a++) expect_hit("R3", 200, a + 8, 555);
    look(200, 9);
    chk("R3", {63'd0, glb0}, 64'd1);

    // R4: nonzero granularity hint rejected
    fill(300, 3, mkw(42, 0, 0, 0, 0, 0, 2));
    chk("R4", {63'd0, err0}, 64'd1);
    expect_miss("R4", 300, 3);
    @(negedge clk);
    chk("R4", {63'd0, err0}, 64'd0);

    // R7: single flush under current space only
    @(negedge clk); flush_one = 1'b1; flush_vpn = VPN_W'(4); cur_asn = ASN_W'(3);
    @(negedge clk); flush_one = 1'b0;
    expect_miss("R7", 4, 3);
    @(negedge clk); flush_one = 1'b1; flush_vpn = VPN_W'(5); cur_asn = ASN_W'(5);
    @(negedge clk); flush_one = 1'b0;
    expect_hit("R7", 5, 3, 27);

    // R6: process flush keeps the global entry
    @(negedge clk); flush_proc = 1'b1;
    @(negedge clk); flush_proc = 1'b0;
    expect_miss("R6", 5, 3);
    expect_miss("R6", 101, 3);
    expect_hit("R6", 200, 1, 555);

    // R5 and R10: full flush wins over a same-cycle tag write
    stage(mkw(77, 1, 1, 0, 0, 0, 0));
    @(negedge clk); flush_all = 1'b1; tag_we = 1'b1; tag_vpn = VPN_W'(400); cur_asn = ASN_W'(3);
    @(negedge clk); flush_all = 1'b0; tag_we = 1'b0;
    expect_miss("R5", 200, 1);
    expect_miss("R10", 400, 3);

    // R12: tag write with same-cycle staging uses the older word
    stage(mkw(273, 6, 5, 0, 0, 0, 0));
    @(negedge clk); stage_we = 1'b1; stage_word = mkw(546, 7, 9, 0, 0, 0, 0);
    tag_we = 1'b1; tag_vpn = VPN_W'(500); cur_asn = ASN_W'(3);
    @(negedge clk); stage_we = 1'b0; tag_we = 1'b0;
    expect_hit("R12", 500, 3, 273);
    tag(501, 3);
    expect_hit("R12", 501, 3, 546);
    chk("R12", {60'd0, wr0}, 64'd9);

    // R11: instruction-side variant forces write enables to zero
    look(500, 3);
    chk("R11", {63'd0, hit1}, 64'd1);
    chk("R11", {60'd0, wr1}, 64'd0);
    chk("R11", {60'd0, rd1}, 64'd6);
    chk("R11", {37'd0, ppn1}, 64'd273);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule